// File: doc/BRIEF.md
# Infrared Pulse Line Converter

This block sits between a UART's serial bit stream and an infrared transceiver. It runs on the system clock and advances its bit-cell timing on a one-cycle enable, `tick16`, which pulses sixteen times per bit. In infrared mode the transmit side sends each bit cell as either a short active-high pulse or no pulse. A data 0 produces a pulse three ticks wide, placed so that its midpoint falls at the centre of the cell. A data 1 produces no pulse, so the line stays low while idle. The receive side brings the raw infrared line through a synchronizer and detects the rising edge of each pulse. It then drives the recovered NRZ bit low for one full bit cell. The UART receiver samples that bit in the usual way.

When the mode input is low, both directions pass straight through with no change. Baud generation and character framing are left to the surrounding UART. The encoder starts a new bit cell on the tick at which the NRZ level it holds changes. After that it counts 16 ticks per cell for as long as the level stays the same.

Top module: `irda_phy`

## Requirements
- R1: After synchronous reset, with `ir_mode` = 1, `tx_nrz` = 1 and `ir_rx_raw` = 0, `ir_tx_out` is 0 and `rx_nrz` is 1.
- R2: In infrared mode (`ir_mode` = 1), a bit cell with data 0 produces exactly one high pulse on `ir_tx_out`. A bit cell with data 1, and an idle line, keep `ir_tx_out` at 0.
- R3: Each transmit pulse is high for exactly 3 ticks of `tick16`.
- R4: The cell phase is counted from 0, where phase 0 is the tick that captured the bit. The pulse is high after the ticks of phases 7, 8 and 9, and low after every other phase.
- R5: The encoder captures `tx_nrz` only on a tick. A changed level restarts the cell at phase 0. An unchanged level advances the phase, which wraps from 15 back to 0, so consecutive equal bits form 16-tick cells.
- R6: Between ticks the encoder output does not change, whatever `tx_nrz` does.
- R7: `ir_rx_raw` passes through a two-flop synchronizer. A rising edge on it drives `rx_nrz` low on the third clock edge. When ticks come at most once every four clocks, this is within one tick.
- R8: Each detected rising edge holds `rx_nrz` low for 16 ticks from the moment of detection. `rx_nrz` then returns to 1 unless a new edge has arrived.
- R9: With `ir_mode` = 0, `ir_tx_out` equals `tx_nrz` and `rx_nrz` equals `ir_rx_raw`, combinationally.
- R10: In infrared mode, while no pulse arrives on `ir_rx_raw` and no hold is running, `rx_nrz` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle enable, 16 per bit time |
| ir_mode | input | 1 | 1 = infrared pulse mode, 0 = NRZ passthrough |
| tx_nrz | input | 1 | NRZ transmit bit from the UART |
| ir_rx_raw | input | 1 | Raw receive line from the transceiver, pulse active high |
| ir_tx_out | output | 1 | Line to the transceiver |
| rx_nrz | output | 1 | Recovered NRZ bit to the UART |

## Verification
On every cycle the assertions check that a pulse is never emitted while the held level is 1. They check that a pulse only begins at phase 7, and that a counter of consecutive pulse ticks never exceeds three. They check that the encoder output moves only after a tick, that a detected edge reloads the full 16-tick hold, and that an idle decoder stays idle. Other behaviours show only in the bench scenarios. These are cell realignment on a level change, the exact pulse position within each of several character patterns, and the bytes recovered through a loopback from transmit to receive. The same applies to the synchronizer latency counted in clock edges, the release of the hold after the 16th tick, and passthrough mode.

// File: rtl/irda_pkg.sv
package irda_pkg;

    localparam int unsigned OVERSAMPLE  = 16;
    localparam int unsigned PULSE_START = 7;
    localparam int unsigned PULSE_WIDTH = 3;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        LINE_NRZ = 1'b0,
        LINE_IR  = 1'b1
    } line_mode_e;

    // True when a cell phase lies inside the pulse window.
    function automatic logic in_window(input int phase, input int first, input int width);
        return (phase >= first) && (phase < first + width);
    endfunction

endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
    parameter int unsigned STAGES = irda_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b0;
                else     s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '0;
                else     s_q <= {s_q[STAGES-2:0], d};
            end
            assign q = s_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irda_pulse_enc.sv
module irda_pulse_enc #(
    parameter int unsigned OVS   = irda_pkg::OVERSAMPLE,
    parameter int unsigned START = irda_pkg::PULSE_START,
    parameter int unsigned WIDTH = irda_pkg::PULSE_WIDTH
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic nrz_in,
    output logic pulse_out
);
    localparam int PW = $clog2(OVS);

    typedef struct packed {
        logic          lvl;
        logic [PW-1:0] phase;
        logic          pulse;
    } cell_t;

    cell_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (tick) begin
            if (nrz_in != cur_q.lvl) begin
                nxt.lvl   = nrz_in;
                nxt.phase = '0;
            end else if (cur_q.phase == PW'(OVS - 1)) begin
                nxt.phase = '0;
            end else begin
                nxt.phase = cur_q.phase + 1'b1;
            end
            nxt.pulse = !nxt.lvl && irda_pkg::in_window(int'(nxt.phase), int'(START), int'(WIDTH));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.lvl   <= 1'b1;
            cur_q.phase <= '0;
            cur_q.pulse <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign pulse_out = cur_q.pulse;

    // Run-length counter used only by the width check.
    logic [PW:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (tick) run_q <= nxt.pulse ? run_q + 1'b1 : '0;
    end

    // R2
    enc_no_pulse_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.pulse |-> !cur_q.lvl);

    // R4
    enc_pulse_start_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cur_q.pulse) |-> (cur_q.phase == PW'(START)));

    // R3
    enc_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        int'(run_q) <= int'(WIDTH));

    // R6
    enc_tick_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(pulse_out));

endmodule

// File: rtl/irda_pulse_dec.sv
module irda_pulse_dec #(
    parameter int unsigned OVS    = irda_pkg::OVERSAMPLE,
    parameter int unsigned STAGES = irda_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ir_in,
    output logic nrz_out
);
    localparam int HW = $clog2(OVS + 1);

    logic          sync_w;
    logic          seen_q;
    logic [HW-1:0] hold_q;
    logic          edge_w;

    irda_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ir_in),
        .q   (sync_w)
    );

    assign edge_w = sync_w && !seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            hold_q <= '0;
        end else begin
            seen_q <= sync_w;
            if (edge_w)
                hold_q <= HW'(OVS);
            else if (tick && hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

    assign nrz_out = (hold_q == '0);

    // R8
    dec_hold_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_w && !seen_q) |=> (hold_q == HW'(OVS)));

    // R10
    dec_idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q == '0 && !sync_w) |=> nrz_out);

endmodule

// File: rtl/irda_phy.sv
module irda_phy #(
    parameter int unsigned OVS    = irda_pkg::OVERSAMPLE,
    parameter int unsigned START  = irda_pkg::PULSE_START,
    parameter int unsigned WIDTH  = irda_pkg::PULSE_WIDTH,
    parameter int unsigned STAGES = irda_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic tick16,
    input  logic ir_mode,
    input  logic tx_nrz,
    input  logic ir_rx_raw,
    output logic ir_tx_out,
    output logic rx_nrz
);
    import irda_pkg::*;

    logic       enc_pulse;
    logic       dec_bit;
    line_mode_e mode;

    assign mode = line_mode_e'(ir_mode);

    irda_pulse_enc #(.OVS(OVS), .START(START), .WIDTH(WIDTH)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .nrz_in    (tx_nrz),
        .pulse_out (enc_pulse)
    );

    irda_pulse_dec #(.OVS(OVS), .STAGES(STAGES)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .ir_in   (ir_rx_raw),
        .nrz_out (dec_bit)
    );

    always_comb begin
        if (mode == LINE_IR) begin
            ir_tx_out = enc_pulse;
            rx_nrz    = dec_bit;
        end else begin
            ir_tx_out = tx_nrz;
            rx_nrz    = ir_rx_raw;
        end
    end

endmodule

// File: tb/test_irda_phy.sv
module test_irda_phy;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0;
    logic ir_mode = 1'b1;
    logic tx_nrz = 1'b1;
    logic rx_drv = 1'b0;
    logic loop_en = 1'b1;
    logic ir_rx_raw;
    logic ir_tx_out;
    logic rx_nrz;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk; // 250 MHz

    assign ir_rx_raw = loop_en ? ir_tx_out : rx_drv;

    irda_phy i_irda_phy (
        .clk       (clk),
        .rst       (rst),
        .tick16    (tick16),
        .ir_mode   (ir_mode),
        .tx_nrz    (tx_nrz),
        .ir_rx_raw (ir_rx_raw),
        .ir_tx_out (ir_tx_out),
        .rx_nrz    (rx_nrz)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    // {byte, expected pulses in a 10-bit frame}
    localparam logic [11:0] VEC [6] = '{
        {8'h00, 4'd9}, {8'hFF, 4'd1}, {8'h55, 4'd5},
        {8'hA5, 4'd5}, {8'h0F, 4'd5}, {8'h80, 4'd8}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One tick, then three idle clocks; returns at a falling edge.
    task automatic step_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick16 = 1'b1;
            @(negedge clk) tick16 = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        int bad;
        int hi;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ir_tx_out == 1'b0, "R1 tx after reset", ir_tx_out, 0);
        chk(rx_nrz == 1'b1, "R1 rx after reset", rx_nrz, 1);

        // Idle line: no pulses out, no low on decode (R2, R10)
        bad = 0; hi = 0;
        for (int i = 0; i < 40; i++) begin
            step_tick(1);
            if (ir_tx_out) hi++;
            if (!rx_nrz) bad++;
        end
        chk(hi == 0, "R2 idle tx stays low", hi, 0);
        chk(bad == 0, "R10 idle rx stays high", bad, 0);

        // Frame vectors with loopback: R3 R4 R5 shape, R2 count, R8 decode
        foreach (VEC[v]) begin
            logic [9:0] frame;
            logic [9:0] got;
            int rises;
            logic prev;
            frame = {1'b1, VEC[v][11:4], 1'b0};
            bad = 0; rises = 0; prev = 1'b0; got = '0;
            for (int b = 0; b < 10; b++) begin
                tx_nrz = frame[b];
                for (int k = 0; k < 16; k++) begin
                    logic expv;
                    step_tick(1);
                    expv = !frame[b] && (k >= 7) && (k <= 9);
                    if (ir_tx_out !== expv) bad++;
                    if (ir_tx_out && !prev) rises++;
                    prev = ir_tx_out;
                    if (k == 12) got[b] = rx_nrz;
                end
            end
            chk(bad == 0, "R4 R3 R5 pulse placement mismatches", bad, 0);
            chk(rises == int'(VEC[v][3:0]), "R2 pulses per frame", rises, int'(VEC[v][3:0]));
            chk(got == frame, "R8 loopback decoded frame", int'(got), int'(frame));
        end

        // Tick gating: pulse appears only on the 8th tick of a 0 cell (R6)
        tx_nrz = 1'b0;
        step_tick(7);
        chk(ir_tx_out == 1'b0, "R4 no pulse before phase 7", ir_tx_out, 0);
        tx_nrz = 1'b1;
        repeat (20) @(negedge clk);
        tx_nrz = 1'b0;
        repeat (3) @(negedge clk);
        chk(ir_tx_out == 1'b0, "R6 output frozen without tick", ir_tx_out, 0);
        step_tick(1);
        chk(ir_tx_out == 1'b1, "R6 pulse on next tick", ir_tx_out, 1);
        step_tick(8);
        tx_nrz = 1'b1;
        step_tick(40);

        // Decoder latency and hold (R7, R8)
        loop_en = 1'b0;
        rx_drv = 1'b0;
        @(negedge clk);
        chk(rx_nrz == 1'b1, "R10 rx high before pulse", rx_nrz, 1);
        rx_drv = 1'b1;
        repeat (2) @(negedge clk);
        chk(rx_nrz == 1'b1, "R7 rx still high after two edges", rx_nrz, 1);
        @(negedge clk);
        chk(rx_nrz == 1'b0, "R7 rx low on third edge", rx_nrz, 0);
        rx_drv = 1'b0;
        step_tick(15);
        chk(rx_nrz == 1'b0, "R8 rx low through 15 ticks", rx_nrz, 0);
        step_tick(1);
        chk(rx_nrz == 1'b1, "R8 rx released after 16th tick", rx_nrz, 1);

        // Passthrough (R9)
        @(negedge clk);
        ir_mode = 1'b0;
        tx_nrz = 1'b0;
        #1 chk(ir_tx_out == 1'b0, "R9 tx pass 0", ir_tx_out, 0);
        tx_nrz = 1'b1;
        #1 chk(ir_tx_out == 1'b1, "R9 tx pass 1", ir_tx_out, 1);
        rx_drv = 1'b1;
        #1 chk(rx_nrz == 1'b1, "R9 rx pass 1", rx_nrz, 1);
        rx_drv = 1'b0;
        #1 chk(rx_nrz == 1'b0, "R9 rx pass 0", rx_nrz, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule